// File: doc/BRIEF.md
# Downstream Request Address Translator

This block sits behind the inbound request decoder of a PCI Express endpoint. It takes one memory read or write request at a time, already split into fields: the index of the base address register that matched, the request address, the length in dwords, and the byte enables for the first and last dword. It turns each request into a burst command on a 32-bit local memory bus. The local address is built from a translation table with one entry per BAR. The table entry supplies the bits above the aperture size, and the request address supplies the offset bits below it.

Before a request is issued, the block checks its byte enables and its BAR index. A write that fails these checks is dropped without any trace on the local bus. A read that fails them raises a one-cycle completer-abort flag and issues nothing. A legal write leaves as one burst. A legal read is capped at 128 beats (512 bytes). A longer read is cut into consecutive capped bursts, and the intake is stalled until the last burst is out.

Top module: `dx_xlate_top`

## Requirements
- R1: The local address is the translation entry of the matched BAR in bits 31..16 and request address bits 15..0 below it. With the default table, BAR0 maps to 0x1000xxxx, BAR1 to 0x4001xxxx, BAR2 to 0x8000xxxx and BAR3 to 0xC000xxxx.
- R2: A legal write produces exactly one write command on the cycle after acceptance. The command has beats equal to the request length, even above 128, and the request's first and last byte enables unchanged.
- R3: A malformed write, including one of length zero, produces no command and no abort flag.
- R4: For a one-dword request, the first byte enable must be non-zero and must be one of 0001, 0010, 0100, 1000, 0011, 1100 or 1111 (contiguous lanes, aligned to their count). The last byte enable must be 0000.
- R5: For a request of two or more dwords, the first byte enable must be 1111. The last byte enable must be 0001, 0011 or 1111, so partial lanes appear only in the final beat.
- R6: A legal read of at most 128 dwords produces one read command on the cycle after acceptance, with beats equal to its length.
- R7: A legal read of more than 128 dwords is issued as consecutive commands on consecutive cycles. Each command has 128 beats except the last, which carries the remainder, and each address is 512 bytes above the previous one. `req_ready` is low from the first command until the last one is issued.
- R8: A malformed read pulses `cpl_abort` for one cycle, one cycle after acceptance, and issues no command.
- R9: A BAR index of 4 or higher is treated as malformed: a write is dropped and a read is aborted.
- R10: During and right after reset, `cmd_valid` and `cpl_abort` are low and `req_ready` is high.
- R11: Among the commands of a split read, the first carries the request's first byte enable. Every command except the last carries 1111 as its last byte enable, and the last command carries the request's last byte enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request fields are valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_bar | input | 3 | Index of the matched BAR |
| req_addr | input | 32 | Request byte address, dword aligned |
| req_len | input | 10 | Length in dwords |
| req_first_be | input | 4 | Byte enables of the first dword |
| req_last_be | input | 4 | Byte enables of the last dword |
| cmd_valid | output | 1 | A local burst command is present this cycle |
| cmd_write | output | 1 | Command direction, 1 for write |
| cmd_addr | output | 32 | Local byte address of the burst |
| cmd_beats | output | 10 | Burst length in 32-bit beats |
| cmd_first_be | output | 4 | Byte enables of the first beat |
| cmd_last_be | output | 4 | Byte enables of the last beat |
| cpl_abort | output | 1 | One-cycle flag requesting a completer-abort response |

## Verification
Every result is registered once. A command or abort flag for an accepted request is therefore due exactly one rising edge after the acceptance edge. The n-th command of a split read is due n edges after that, with `req_ready` returning high on the edge that issues the final piece. The bench drives inputs on falling edges and reads the outputs on the next falling edge. For split reads it reads one piece per falling edge, and it checks one edge beyond the last piece to confirm the stream has ended.

// File: rtl/dx_xlate_pkg.sv
package dx_xlate_pkg;

    localparam int BE_W = 4;

    typedef logic [BE_W-1:0] be_t;

    typedef enum logic [1:0] {
        VD_DROP  = 2'd0,
        VD_ISSUE = 2'd1,
        VD_ABORT = 2'd2
    } verdict_e;

    // Lanes contiguous and aligned to their count (1, 2 or 4 bytes).
    function automatic logic lane_set_ok(be_t be);
        int n;
        logic ok;
        n = $countones(be);
        case (n)
            1:       ok = 1'b1;
            2:       ok = (be == 4'b0011) || (be == 4'b1100);
            4:       ok = 1'b1;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Final beat of a burst: an aligned set that starts at lane 0.
    function automatic logic tail_ok(be_t be);
        return lane_set_ok(be) && be[0];
    endfunction

    function automatic logic be_pair_ok(logic single, be_t fbe, be_t lbe);
        if (single)
            return lane_set_ok(fbe) && (lbe == '0);
        else
            return (fbe == '1) && tail_ok(lbe);
    endfunction

endpackage

// File: rtl/dx_addr_map.sv
module dx_addr_map #(
    parameter int NUM_BAR    = 4,
    parameter int BAR_IDX_W  = 3,
    parameter int REQ_AW     = 32,
    parameter int LA_W       = 32,
    parameter int APERTURE_W = 16,
    parameter logic [NUM_BAR*LA_W-1:0] XLATE_TABLE = '0
) (
    input  logic [BAR_IDX_W-1:0] bar,
    input  logic [REQ_AW-1:0]    addr,
    output logic [LA_W-1:0]      local_addr,
    output logic                 bar_ok
);
    localparam int HI_W = LA_W - APERTURE_W;
    localparam int IW   = BAR_IDX_W + 1;
    localparam logic [IW-1:0] NB = IW'(NUM_BAR);

    logic [NUM_BAR-1:0][HI_W-1:0] upper;
    logic [HI_W-1:0]              hi;
    logic                         unused_addr_hi;

    genvar g;
    generate
        for (g = 0; g < NUM_BAR; g++) begin : g_entry
            assign upper[g] = XLATE_TABLE[g*LA_W+APERTURE_W +: HI_W];
        end
    endgenerate

    assign unused_addr_hi = ^addr[REQ_AW-1:APERTURE_W];

    always_comb begin
        bar_ok = ({1'b0, bar} < NB);
        hi     = '0;
        for (int i = 0; i < NUM_BAR; i++) begin
            if ({1'b0, bar} == IW'(i))
                hi = upper[i];
        end
        local_addr = {hi, addr[APERTURE_W-1:0]};
    end
endmodule

// File: rtl/dx_be_check.sv
module dx_be_check
    import dx_xlate_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             is_write,
    input  logic             bar_ok,
    input  logic [LEN_W-1:0] len,
    input  be_t              fbe,
    input  be_t              lbe,
    output verdict_e         verdict
);
    logic legal;

    always_comb begin
        legal = bar_ok && (len != '0) &&
                be_pair_ok(len == LEN_W'(1), fbe, lbe);
        if (legal)
            verdict = VD_ISSUE;
        else if (is_write)
            verdict = VD_DROP;
        else
            verdict = VD_ABORT;
    end
endmodule

// File: rtl/dx_burst_split.sv
module dx_burst_split
    import dx_xlate_pkg::*;
#(
    parameter int LA_W      = 32,
    parameter int LEN_W     = 10,
    parameter int MAX_RD_DW = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_write,
    input  verdict_e         verdict,
    input  logic [LA_W-1:0]  base_addr,
    input  logic [LEN_W-1:0] len,
    input  be_t              fbe,
    input  be_t              lbe,
    output logic             busy,
    output logic             cmd_valid,
    output logic             cmd_write,
    output logic [LA_W-1:0]  cmd_addr,
    output logic [LEN_W-1:0] cmd_beats,
    output be_t              cmd_first_be,
    output be_t              cmd_last_be,
    output logic             cpl_abort
);
    localparam logic [LEN_W-1:0] CAP  = LEN_W'(MAX_RD_DW);
    localparam logic [LA_W-1:0]  STEP = LA_W'(MAX_RD_DW * 4);

    logic [LA_W-1:0]  next_addr;
    logic [LEN_W-1:0] rem;
    be_t              tail_be;
    logic [LEN_W-1:0] head_piece;
    logic [LEN_W-1:0] rest_piece;

    assign head_piece = (len > CAP) ? CAP : len;
    assign rest_piece = (rem > CAP) ? CAP : rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy         <= 1'b0;
            next_addr    <= '0;
            rem          <= '0;
            tail_be      <= '0;
            cmd_valid    <= 1'b0;
            cmd_write    <= 1'b0;
            cmd_addr     <= '0;
            cmd_beats    <= '0;
            cmd_first_be <= '0;
            cmd_last_be  <= '0;
            cpl_abort    <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            cpl_abort <= 1'b0;
            if (busy) begin
                cmd_valid    <= 1'b1;
                cmd_write    <= 1'b0;
                cmd_addr     <= next_addr;
                cmd_beats    <= rest_piece;
                cmd_first_be <= '1;
                cmd_last_be  <= (rem > CAP) ? be_t'('1) : tail_be;
                rem          <= rem - rest_piece;
                next_addr    <= next_addr + STEP;
                busy         <= (rem > CAP);
            end else if (start) begin
                case (verdict)
                    VD_ISSUE: begin
                        cmd_valid    <= 1'b1;
                        cmd_write    <= is_write;
                        cmd_addr     <= base_addr;
                        cmd_first_be <= fbe;
                        if (is_write) begin
                            cmd_beats   <= len;
                            cmd_last_be <= lbe;
                        end else begin
                            cmd_beats   <= head_piece;
                            cmd_last_be <= (len > CAP) ? be_t'('1) : lbe;
                            rem         <= len - head_piece;
                            next_addr   <= base_addr + STEP;
                            tail_be     <= lbe;
                            busy        <= (len > CAP);
                        end
                    end
                    VD_ABORT: cpl_abort <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dx_xlate_top.sv
module dx_xlate_top
    import dx_xlate_pkg::*;
#(
    parameter int NUM_BAR    = 4,
    parameter int BAR_IDX_W  = 3,
    parameter int REQ_AW     = 32,
    parameter int LA_W       = 32,
    parameter int APERTURE_W = 16,
    parameter int LEN_W      = 10,
    parameter int MAX_RD_DW  = 128,
    parameter logic [NUM_BAR*LA_W-1:0] XLATE_TABLE =
        {32'hC000_0000, 32'h8000_0000, 32'h4001_0000, 32'h1000_0000}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [BAR_IDX_W-1:0] req_bar,
    input  logic [REQ_AW-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [3:0]           req_first_be,
    input  logic [3:0]           req_last_be,
    output logic                 cmd_valid,
    output logic                 cmd_write,
    output logic [LA_W-1:0]      cmd_addr,
    output logic [LEN_W-1:0]     cmd_beats,
    output logic [3:0]           cmd_first_be,
    output logic [3:0]           cmd_last_be,
    output logic                 cpl_abort
);
    logic [LA_W-1:0] mapped_addr;
    logic            bar_ok;
    verdict_e        verdict;
    logic            busy;
    logic            accept;

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    dx_addr_map #(
        .NUM_BAR(NUM_BAR), .BAR_IDX_W(BAR_IDX_W), .REQ_AW(REQ_AW),
        .LA_W(LA_W), .APERTURE_W(APERTURE_W), .XLATE_TABLE(XLATE_TABLE)
    ) map_i (
        .bar(req_bar), .addr(req_addr),
        .local_addr(mapped_addr), .bar_ok(bar_ok)
    );

    dx_be_check #(.LEN_W(LEN_W)) chk_be_i (
        .is_write(req_write), .bar_ok(bar_ok), .len(req_len),
        .fbe(req_first_be), .lbe(req_last_be), .verdict(verdict)
    );

    dx_burst_split #(
        .LA_W(LA_W), .LEN_W(LEN_W), .MAX_RD_DW(MAX_RD_DW)
    ) split_i (
        .clk(clk), .rst(rst), .start(accept), .is_write(req_write),
        .verdict(verdict), .base_addr(mapped_addr), .len(req_len),
        .fbe(req_first_be), .lbe(req_last_be), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .cmd_beats(cmd_beats), .cmd_first_be(cmd_first_be),
        .cmd_last_be(cmd_last_be), .cpl_abort(cpl_abort)
    );
endmodule

// File: rtl/dx_xlate_chk.sv
module dx_xlate_chk #(
    parameter int LA_W      = 32,
    parameter int LEN_W     = 10,
    parameter int MAX_RD_DW = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             cmd_valid,
    input logic             cmd_write,
    input logic [LA_W-1:0]  cmd_addr,
    input logic [LEN_W-1:0] cmd_beats,
    input logic [3:0]       cmd_first_be,
    input logic [3:0]       cmd_last_be,
    input logic             cpl_abort
);
    localparam logic [LEN_W-1:0] CAP  = LEN_W'(MAX_RD_DW);
    localparam logic [LA_W-1:0]  STEP = LA_W'(MAX_RD_DW * 4);

    // R6: a local read never exceeds the cap and is never empty
    assert_read_cap_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_write) |-> (cmd_beats <= CAP && cmd_beats != '0));

    // R8: an abort never comes with a local command
    assert_abort_no_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        cpl_abort |-> !cmd_valid);

    // R7: while stalled, the next piece follows at +512 bytes
    assert_split_step_R7: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> (cmd_valid && !cmd_write &&
                        cmd_addr == $past(cmd_addr) + STEP));

    // R5: multi-beat commands start with all lanes enabled
    assert_burst_head_be_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_beats > LEN_W'(1)) |-> (cmd_first_be == 4'hF));

    // R11: a piece that is not the last ends with all lanes enabled
    assert_mid_piece_be_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !req_ready) |-> (cmd_last_be == 4'hF && cmd_beats == CAP));

    // R10: the cycle after reset is idle
    assert_reset_idle_R10: assert property (@(posedge clk)
        $past(rst) |-> (!cmd_valid && !cpl_abort && req_ready));
endmodule

bind dx_xlate_top dx_xlate_chk #(
    .LA_W(LA_W), .LEN_W(LEN_W), .MAX_RD_DW(MAX_RD_DW)
) chk_i (
    .clk(clk), .rst(rst), .req_ready(req_ready), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_beats(cmd_beats),
    .cmd_first_be(cmd_first_be), .cmd_last_be(cmd_last_be),
    .cpl_abort(cpl_abort)
);

// File: tb/dx_xlate_top_tb_top.sv
module dx_xlate_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [2:0]  req_bar = '0;
    logic [31:0] req_addr = '0;
    logic [9:0]  req_len = '0;
    logic [3:0]  req_first_be = '0;
    logic [3:0]  req_last_be = '0;
    logic        cmd_valid;
    logic        cmd_write;
    logic [31:0] cmd_addr;
    logic [9:0]  cmd_beats;
    logic [3:0]  cmd_first_be;
    logic [3:0]  cmd_last_be;
    logic        cpl_abort;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dx_xlate_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bar(req_bar), .req_addr(req_addr),
        .req_len(req_len), .req_first_be(req_first_be),
        .req_last_be(req_last_be), .cmd_valid(cmd_valid),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_beats(cmd_beats),
        .cmd_first_be(cmd_first_be), .cmd_last_be(cmd_last_be),
        .cpl_abort(cpl_abort)
    );

    // kind: 0 nothing expected, 1 command, 2 abort
    typedef struct packed {
        logic        wr;
        logic [2:0]  bar;
        logic [31:0] addr;
        logic [9:0]  len;
        logic [3:0]  fbe;
        logic [3:0]  lbe;
        logic [1:0]  kind;
        logic [31:0] eaddr;
        logic [7:0]  rid;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 32'hABCD_0100, 10'd4,   4'hF, 4'h3, 2'd1, 32'h1000_0100, 8'd1}, // R1
        '{1'b1, 3'd1, 32'h0000_FFFC, 10'd1,   4'hC, 4'h0, 2'd1, 32'h4001_FFFC, 8'd4}, // R4
        '{1'b1, 3'd2, 32'h0000_0040, 10'd1,   4'h6, 4'h0, 2'd0, 32'h0,         8'd4}, // R4
        '{1'b1, 3'd3, 32'h0000_0040, 10'd1,   4'h5, 4'h0, 2'd0, 32'h0,         8'd4}, // R4
        '{1'b1, 3'd0, 32'h0000_0040, 10'd1,   4'h7, 4'h0, 2'd0, 32'h0,         8'd4}, // R4
        '{1'b1, 3'd0, 32'h0000_0040, 10'd3,   4'hE, 4'hF, 2'd0, 32'h0,         8'd5}, // R5
        '{1'b1, 3'd0, 32'h0000_0040, 10'd2,   4'hF, 4'h2, 2'd0, 32'h0,         8'd5}, // R5
        '{1'b1, 3'd5, 32'h0000_0040, 10'd1,   4'hF, 4'h0, 2'd0, 32'h0,         8'd9}, // R9
        '{1'b0, 3'd2, 32'h0012_2000, 10'd128, 4'hF, 4'hF, 2'd1, 32'h8000_2000, 8'd6}, // R6
        '{1'b0, 3'd3, 32'h7777_0010, 10'd1,   4'h8, 4'h0, 2'd1, 32'hC000_0010, 8'd4}, // R4
        '{1'b0, 3'd0, 32'h0000_0040, 10'd1,   4'h0, 4'h0, 2'd2, 32'h0,         8'd8}, // R8
        '{1'b0, 3'd4, 32'h0000_0040, 10'd1,   4'hF, 4'h0, 2'd2, 32'h0,         8'd9}, // R9
        '{1'b0, 3'd1, 32'h0000_0040, 10'd0,   4'hF, 4'h0, 2'd2, 32'h0,         8'd8}, // R8
        '{1'b1, 3'd0, 32'h0000_0040, 10'd0,   4'hF, 4'h0, 2'd0, 32'h0,         8'd3}, // R3
        '{1'b1, 3'd2, 32'h5555_0008, 10'd8,   4'hF, 4'h1, 2'd1, 32'h8000_0008, 8'd2}, // R2
        '{1'b0, 3'd1, 32'h0000_0040, 10'd2,   4'hF, 4'hC, 2'd2, 32'h0,         8'd5}, // R5
        '{1'b1, 3'd3, 32'h0000_0040, 10'd1,   4'hF, 4'h1, 2'd0, 32'h0,         8'd4}  // R4
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic wr, input logic [2:0] bar, input logic [31:0] addr,
                        input logic [9:0] len, input logic [3:0] fbe, input logic [3:0] lbe);
        @(negedge clk);
        req_write    = wr;
        req_bar      = bar;
        req_addr     = addr;
        req_len      = len;
        req_first_be = fbe;
        req_last_be  = lbe;
        req_valid    = 1'b1;
        @(negedge clk);
        req_valid    = 1'b0;
    endtask

    task automatic expect_cmd(input string req, input logic wr, input logic [31:0] addr,
                              input logic [9:0] beats, input logic [3:0] fbe,
                              input logic [3:0] lbe, input logic rdy);
        chk({req, " valid"}, cmd_valid, 1'b1);
        chk({req, " write"}, cmd_write, wr);
        chk({req, " addr"}, cmd_addr, addr);
        chk({req, " beats"}, cmd_beats, beats);
        chk({req, " first_be"}, cmd_first_be, fbe);
        chk({req, " last_be"}, cmd_last_be, lbe);
        chk({req, " ready"}, req_ready, rdy);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R10: outputs idle while in reset
        @(negedge clk);
        chk("R10 valid in reset", cmd_valid, 1'b0);
        chk("R10 abort in reset", cpl_abort, 1'b0);
        chk("R10 ready in reset", req_ready, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 valid after reset", cmd_valid, 1'b0);
        chk("R10 ready after reset", req_ready, 1'b1);

        // Vector table: one request, result one edge later
        for (int i = 0; i < NV; i++) begin
            string tag;
            send(VECS[i].wr, VECS[i].bar, VECS[i].addr, VECS[i].len,
                 VECS[i].fbe, VECS[i].lbe);
            tag = $sformatf("R%0d vec%0d", VECS[i].rid, i);
            chk({tag, " abort"}, cpl_abort, VECS[i].kind == 2'd2);
            if (VECS[i].kind == 2'd1)
                expect_cmd(tag, VECS[i].wr, VECS[i].eaddr, VECS[i].len,
                           VECS[i].fbe, VECS[i].lbe, 1'b1);
            else
                chk({tag, " no cmd"}, cmd_valid, 1'b0);
            @(negedge clk);
            chk({tag, " pulse ends"}, cmd_valid | cpl_abort, 1'b0);
        end

        // R7 R11: read of 300 dwords on BAR1 -> 128, 128, 44
        send(1'b0, 3'd1, 32'h0000_1000, 10'd300, 4'hF, 4'h3);
        expect_cmd("R7 R11 piece0", 1'b0, 32'h4001_1000, 10'd128, 4'hF, 4'hF, 1'b0);
        @(negedge clk);
        expect_cmd("R7 R11 piece1", 1'b0, 32'h4001_1200, 10'd128, 4'hF, 4'hF, 1'b0);
        @(negedge clk);
        expect_cmd("R7 R11 piece2", 1'b0, 32'h4001_1400, 10'd44, 4'hF, 4'h3, 1'b1);
        @(negedge clk);
        chk("R7 stream ended", cmd_valid, 1'b0);
        chk("R7 ready restored", req_ready, 1'b1);

        // R7 R11: exact multiple, 256 dwords on BAR3 -> 128, 128
        send(1'b0, 3'd3, 32'h0000_F000, 10'd256, 4'hF, 4'h1);
        expect_cmd("R7 R11 even0", 1'b0, 32'hC000_F000, 10'd128, 4'hF, 4'hF, 1'b0);
        @(negedge clk);
        expect_cmd("R7 R11 even1", 1'b0, 32'hC000_F200, 10'd128, 4'hF, 4'h1, 1'b1);
        @(negedge clk);
        chk("R7 even ended", cmd_valid, 1'b0);

        // R6: read of 129 dwords is the smallest split
        send(1'b0, 3'd0, 32'h0000_0000, 10'd129, 4'hF, 4'hF);
        expect_cmd("R6 R7 cap0", 1'b0, 32'h1000_0000, 10'd128, 4'hF, 4'hF, 1'b0);
        @(negedge clk);
        expect_cmd("R7 cap1", 1'b0, 32'h1000_0200, 10'd1, 4'hF, 4'hF, 1'b1);

        // R2: write of 300 dwords is not split
        send(1'b1, 3'd2, 32'h0000_0400, 10'd300, 4'hF, 4'h3);
        expect_cmd("R2 long write", 1'b1, 32'h8000_0400, 10'd300, 4'hF, 4'h3, 1'b1);
        @(negedge clk);
        chk("R2 single command", cmd_valid, 1'b0);

        finish_run();
    end
endmodule